// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Condition Flags

This block is the arithmetic core of a small 8-bit processor. It computes eight accumulator operations in one combinational pass: add, add with carry, subtract, subtract with borrow, AND, XOR, OR and compare. A 3-bit select picks the operation. The block outputs the new accumulator value and a write-enable that tells the register file whether to store it.

Four condition flags are held in registers inside the block: zero, subtract, half-carry and carry. They change on a clock edge when a strobe is raised. The subtract and half-carry flags record what a later decimal-adjust step needs: whether the last operation subtracted, and whether the low nibble carried or borrowed.

A second path adds a 16-bit register pair into the HL pair. It updates the subtract, half-carry and carry flags and leaves the zero flag as it was. The carry-in for the two carry-using operations is the block's own registered carry flag.

Top module: `acc_alu`

## Requirements
- R1: The operation select `op` encodes 000 add, 001 add-with-carry, 010 subtract, 011 subtract-with-borrow, 100 AND, 101 XOR, 110 OR, 111 compare. `acc_out` is the low 8 bits of acc_in+opnd(+C) or acc_in-opnd(-C), where C is the registered carry flag and is used only by 001 and 011.
- R2: For 100, 101 and 110, `acc_out` is the bitwise AND, XOR or OR of `acc_in` and `opnd`.
- R3: Compare (111) sets the flags from acc_in-opnd, the same way subtract does, and never asserts `acc_we`.
- R4: `acc_we` is high exactly when `alu_en` is high and `op` is not 111.
- R5: Half-carry is the carry out of bit 3 for 000 and 001, and the borrow out of bit 3 for 010, 011 and 111. For 001 and 011, the incoming carry is part of that same nibble sum or difference, so 0x0F+0x00+1 gives half-carry 1.
- R6: Carry is the carry out of bit 7 for 000 and 001, and the borrow out of bit 7 for 010, 011 and 111. The borrow includes the incoming carry on 011.
- R7: The subtract flag becomes 0 after 000 and 001, and 1 after 010, 011 and 111.
- R8: After 100 the flags are half-carry 1, subtract 0 and carry 0. After 101 and 110, half-carry, subtract and carry are all 0.
- R9: For all eight operations, the zero flag becomes 1 exactly when the 8-bit result is 0x00. For compare, that result is the difference.
- R10: `hl_out` is always (hl_in+pair_in) mod 2^16. On an edge with `pair_en` high and `alu_en` low, the flags change as follows: subtract is cleared, half-carry takes the carry out of bit 11, carry takes the carry out of bit 15, and zero keeps its value.
- R11: Flags change only on a rising edge where `alu_en` or `pair_en` is high. When both strobes are high, the 8-bit operation decides the flags.
- R12: A synchronous reset (`rst` high at a rising edge) clears all four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alu_en | input | 1 | Commits the 8-bit operation's flags at the edge |
| op | input | 3 | Operation select |
| acc_in | input | 8 | Current accumulator |
| opnd | input | 8 | Second operand |
| pair_en | input | 1 | Commits the 16-bit pair-add flags at the edge |
| hl_in | input | 16 | Current HL pair |
| pair_in | input | 16 | Register pair added into HL |
| acc_out | output | 8 | New accumulator value |
| acc_we | output | 1 | Accumulator write-enable |
| hl_out | output | 16 | New HL value |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Subtract flag |
| flag_h | output | 1 | Half-carry flag |
| flag_c | output | 1 | Carry flag |

## Verification
The hardest case to reach is a carry-using operation whose result depends on the carry flag that the previous edge left behind, because no port sets that flag directly. Before every vector, the bench runs a setup addition: 0xFF+0x01 leaves carry set and 0x00+0x00 leaves it clear. It then sweeps all 256 accumulator values against a set of corner operands under both carry states. The pair add needs the same kind of setup, this time for the zero flag, so that the bench can show the pair add keeps a zero flag that was 1 and also one that was 0.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W = 8,
  parameter int NIB = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alu_en,
  input  logic [2:0]    op,
  input  logic [W-1:0]  acc_in,
  input  logic [W-1:0]  opnd,
  input  logic          pair_en,
  input  logic [2*W-1:0] hl_in,
  input  logic [2*W-1:0] pair_in,
  output logic [W-1:0]  acc_out,
  output logic          acc_we,
  output logic [2*W-1:0] hl_out,
  output logic          flag_z,
  output logic          flag_n,
  output logic          flag_h,
  output logic          flag_c
);
  localparam int PW = 2 * W;
  localparam int HB = PW - NIB;
  localparam logic [2:0] OP_ADD = 3'd0, OP_ADC = 3'd1, OP_SUB = 3'd2, OP_SBC = 3'd3,
                         OP_AND = 3'd4, OP_XOR = 3'd5, OP_OR  = 3'd6, OP_CP  = 3'd7;

  logic            cin;
  logic [NIB:0]    add_lo, sub_lo;
  logic [W:0]      add_wd, sub_wd;
  logic [W-1:0]    res;
  logic            nz, nn, nh, nc;
  logic [HB:0]     pr_lo;
  logic [PW:0]     pr_wd;

  assign cin = (op == OP_ADC || op == OP_SBC) ? flag_c : 1'b0;

  assign add_lo = {1'b0, acc_in[NIB-1:0]} + {1'b0, opnd[NIB-1:0]} + {{NIB{1'b0}}, cin};
  assign sub_lo = {1'b0, acc_in[NIB-1:0]} - {1'b0, opnd[NIB-1:0]} - {{NIB{1'b0}}, cin};
  assign add_wd = {1'b0, acc_in} + {1'b0, opnd} + {{W{1'b0}}, cin};
  assign sub_wd = {1'b0, acc_in} - {1'b0, opnd} - {{W{1'b0}}, cin};

  always_comb begin
    res = add_wd[W-1:0];
    nn  = 1'b0;
    nh  = add_lo[NIB];
    nc  = add_wd[W];
    unique case (op)
      OP_ADD, OP_ADC: ;
      OP_SUB, OP_SBC, OP_CP: begin
        res = sub_wd[W-1:0];
        nn  = 1'b1;
        nh  = sub_lo[NIB];
        nc  = sub_wd[W];
      end
      OP_AND: begin res = acc_in & opnd; nh = 1'b1; nc = 1'b0; end
      OP_XOR: begin res = acc_in ^ opnd; nh = 1'b0; nc = 1'b0; end
      default: begin res = acc_in | opnd; nh = 1'b0; nc = 1'b0; end
    endcase
    nz = (res == '0);
  end

  assign acc_out = res;
  assign acc_we  = alu_en && (op != OP_CP);

  assign pr_lo  = {1'b0, hl_in[HB-1:0]} + {1'b0, pair_in[HB-1:0]};
  assign pr_wd  = {1'b0, hl_in} + {1'b0, pair_in};
  assign hl_out = pr_wd[PW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_z <= 1'b0;
      flag_n <= 1'b0;
      flag_h <= 1'b0;
      flag_c <= 1'b0;
    end else if (alu_en) begin
      flag_z <= nz;
      flag_n <= nn;
      flag_h <= nh;
      flag_c <= nc;
    end else if (pair_en) begin
      flag_n <= 1'b0;
      flag_h <= pr_lo[HB];
      flag_c <= pr_wd[PW];
    end
  end

  AST_CP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CP) |-> !acc_we); // R3
  AST_WE_FOLLOWS_EN: assert property (@(posedge clk) disable iff (rst)
    !alu_en |-> !acc_we); // R4
  AST_SUB_FLAG: assert property (@(posedge clk) disable iff (rst)
    alu_en && (op == OP_SUB || op == OP_SBC || op == OP_CP) |=> flag_n); // R7
  AST_AND_FLAGS: assert property (@(posedge clk) disable iff (rst)
    alu_en && (op == OP_AND) |=> flag_h && !flag_c && !flag_n); // R8
  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (rst)
    acc_we |=> flag_z == ($past(acc_out) == '0)); // R9
  AST_PAIR_KEEPS_Z: assert property (@(posedge clk) disable iff (rst)
    !alu_en && pair_en |=> (flag_z == $past(flag_z)) && !flag_n); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !alu_en && !pair_en |=> $stable({flag_z, flag_n, flag_h, flag_c})); // R11
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> !flag_z && !flag_n && !flag_h && !flag_c); // R12
endmodule

// File: tb/acc_alu_test.sv
module acc_alu_test;
  logic clk = 1'b0, rst = 1'b1, alu_en = 1'b0, pair_en = 1'b0;
  logic [2:0] op = 3'd0;
  logic [7:0] acc_in = 8'd0, opnd = 8'd0;
  logic [15:0] hl_in = 16'd0, pair_in = 16'd0;
  logic [7:0] acc_out;
  logic acc_we, flag_z, flag_n, flag_h, flag_c;
  logic [15:0] hl_out;
  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  acc_alu uut (.clk(clk), .rst(rst), .alu_en(alu_en), .op(op), .acc_in(acc_in), .opnd(opnd),
    .pair_en(pair_en), .hl_in(hl_in), .pair_in(pair_in), .acc_out(acc_out), .acc_we(acc_we),
    .hl_out(hl_out), .flag_z(flag_z), .flag_n(flag_n), .flag_h(flag_h), .flag_c(flag_c));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !done) begin
      failures = failures + 1;
      $display("FAIL watchdog R11: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] o, input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    alu_en = 1'b1; pair_en = 1'b0; op = o; acc_in = a; opnd = b;
    @(posedge clk); #1;
    alu_en = 1'b0;
  endtask

  task automatic vec(input logic [2:0] o, input logic [7:0] a, input logic [7:0] b, input bit ci);
    int s, lo, r; bit z, n, h, c, we;
    run_op(3'd0, ci ? 8'hFF : 8'h00, ci ? 8'h01 : 8'h00);
    case (o)
      3'd0, 3'd1: begin
        s = a + b + ((o == 3'd1) ? ci : 0);
        lo = (a % 16) + (b % 16) + ((o == 3'd1) ? ci : 0);
        r = s % 256; n = 0; h = lo > 15; c = s > 255;
      end
      3'd2, 3'd3, 3'd7: begin
        s = a - b - ((o == 3'd3) ? ci : 0);
        lo = (a % 16) - (b % 16) - ((o == 3'd3) ? ci : 0);
        r = (s + 512) % 256; n = 1; h = lo < 0; c = s < 0;
      end
      3'd4: begin r = a & b; n = 0; h = 1; c = 0; end
      3'd5: begin r = a ^ b; n = 0; h = 0; c = 0; end
      default: begin r = a | b; n = 0; h = 0; c = 0; end
    endcase
    z = (r == 0); we = (o != 3'd7);
    @(negedge clk);
    alu_en = 1'b1; op = o; acc_in = a; opnd = b;
    #1;
    if (o != 3'd7) chk(o >= 3'd4 ? "R2 logic result" : "R1 arith result", {24'd0, acc_out}, r);
    chk(o == 3'd7 ? "R3 compare no write" : "R4 write enable", {31'd0, acc_we}, {31'd0, we});
    @(posedge clk); #1;
    alu_en = 1'b0;
    chk("R5 R6 R7 R8 R9 flags zn hc", {28'd0, flag_z, flag_n, flag_h, flag_c}, {28'd0, z, n, h, c});
  endtask

  logic [7:0] corners [10] = '{8'h00, 8'h0F, 8'h10, 8'hFF, 8'h01, 8'h80, 8'h7F, 8'hF0, 8'h5A, 8'hA5};
  logic [15:0] pcorn [8] = '{16'h0000, 16'h0FFF, 16'h1000, 16'hFFFF, 16'h8000, 16'h0001, 16'h7FFF, 16'hF001};

  initial begin
    repeat (2) @(posedge clk);
    #1;
    chk("R12 reset clears flags", {28'd0, flag_z, flag_n, flag_h, flag_c}, 32'd0);
    @(negedge clk); rst = 1'b0;

    // R5 carry-in inside the nibble sum
    vec(3'd1, 8'h0F, 8'h00, 1'b1);
    vec(3'd3, 8'h10, 8'h00, 1'b1);
    vec(3'd3, 8'h00, 8'hFF, 1'b1);

    for (int o = 0; o < 8; o++)
      for (int a = 0; a < 256; a++)
        for (int k = 0; k < 10; k++)
          for (int ci = 0; ci < 2; ci++)
            vec(o[2:0], a[7:0], corners[k], ci[0]);

    // R10 pair add with both zero states
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int zs = 0; zs < 2; zs++) begin
          int s, lo;
          run_op(3'd0, zs[0] ? 8'h00 : 8'h01, 8'h00);
          s = pcorn[i] + pcorn[j];
          lo = (pcorn[i] % 4096) + (pcorn[j] % 4096);
          @(negedge clk);
          pair_en = 1'b1; hl_in = pcorn[i]; pair_in = pcorn[j];
          #1;
          chk("R10 pair sum", {16'd0, hl_out}, s % 65536);
          @(posedge clk); #1;
          pair_en = 1'b0;
          chk("R10 pair flags", {28'd0, flag_z, flag_n, flag_h, flag_c},
              {28'd0, zs[0], 1'b0, lo > 4095, s > 65535});
        end

    // R11 idle edges hold flags
    run_op(3'd2, 8'h00, 8'h01);
    @(negedge clk); op = 3'd4; acc_in = 8'h00; opnd = 8'h00; hl_in = 16'hFFFF; pair_in = 16'h0001;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 idle hold", {28'd0, flag_z, flag_n, flag_h, flag_c}, {28'd0, 4'b0111});

    // R11 both strobes: 8-bit operation wins
    @(negedge clk);
    alu_en = 1'b1; pair_en = 1'b1; op = 3'd5; acc_in = 8'h33; opnd = 8'h33;
    hl_in = 16'hFFFF; pair_in = 16'hFFFF;
    @(posedge clk); #1;
    alu_en = 1'b0; pair_en = 1'b0;
    chk("R11 alu over pair", {28'd0, flag_z, flag_n, flag_h, flag_c}, {28'd0, 4'b1000});

    // R12 mid-run reset
    run_op(3'd0, 8'hFF, 8'h01);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    chk("R12 reset mid-run", {28'd0, flag_z, flag_n, flag_h, flag_c}, 32'd0);
    @(negedge clk); rst = 1'b0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule